// File: doc/BRIEF.md
# Four-Channel Buffered Compare Timer

This block is a 16-bit up-counter with four compare channels, meant to sit behind a small register port in a larger chip. The counter advances either on an internal clock-enable strobe or on a chosen edge of an external event line. Each channel keeps a software-visible compare value and, behind it, a hidden copy that the counter is actually compared against. A channel raises a one-cycle interrupt pulse when the counter steps onto that hidden value. Four extra input pins each have their own edge detector with a selectable active edge, and report a one-cycle pulse.

While the run bit is clear, the counter sits at all-ones internally, but software reading it sees zero. Setting the run bit lets the first counted step wrap the counter to zero, after which it counts upward and wraps at the top. Software uses the block by writing the control word, loading compare values and, if needed, setting the pin edge selections.

Register map (address : meaning): 0 control (bit 0 run, bit 1 count source: 0 strobe, 1 event line, bits 3:2 event-line edge); 1 counter, read-only; 2 pin edge selections (pin k in bits 2k+1:2k); 4 to 7 compare value of channels 0 to 3. Edge selection code: 00 none, 01 rising, 10 falling, 11 both. Unused addresses read zero.

Top module: `cmp4_timer`

## Requirements
- R1: After reset the counter reads 0000h, every compare value reads 0000h, and all interrupt and pin-edge outputs are 0.
- R2: While the run bit (control bit 0) is 0, a read of address 1 returns 0000h and the counter does not advance.
- R3: After the run bit is set, the counter reads FFFFh until the first counted step, which brings it to 0000h; counting continues upward and wraps from FFFFh to 0000h.
- R4: With control bit 1 at 0, the counter advances by one on each clock where tick_en is 1 and holds otherwise.
- R5: With control bit 1 at 1, tick_en is ignored and the counter advances once for each evt_in edge matching control bits 3:2 (00 none, 01 rising, 10 falling, 11 both); the edge is taken between the last sampled value and the current one.
- R6: A compare value written at addresses 4 to 7 reads back at once, is copied to the hidden buffer on the following clock, and only counter values reached after that copy are compared with it.
- R7: When the counter advances onto a channel's buffered value, that channel's cmp_irq bit is 1 for exactly that one cycle; several channels can fire together.
- R8: No cmp_irq pulse occurs while the run bit is 0, even if a buffer holds FFFFh.
- R9: Each pin_in bit has its own edge detector selected by 2-bit fields at address 2 (pin k at bits 2k+1:2k, same code as R5); a matching change produces a one-cycle pin_edge pulse in the cycle after the clock that samples it, and code 00 never pulses.
- R10: A write to address 1 is ignored: the counter value is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Internal count strobe |
| evt_in | input | 1 | External event line |
| pin_in | input | 4 | Inputs to the four pin edge detectors |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address for read and write |
| wdata | input | 16 | Register write data |
| rdata | output | 16 | Register read data, combinational on addr |
| cmp_irq | output | 4 | Per-channel compare-match pulses |
| pin_edge | output | 4 | Per-pin detected-edge pulses |

## Verification
A compare-value write and a compare match can land in the same clock, and the bench sets this up on purpose. It rewrites channel 2 on the exact clock the counter steps onto that channel's old value, and expects the pulse from the old buffer. It also rewrites channel 0 one step ahead of the counter and expects no pulse, because the new value reaches the buffer too late. Each result is checked at cmp_irq in the cycle after the edge, and the new values are confirmed by reading the compare registers back.

// File: rtl/tmr4_pkg.sv
package tmr4_pkg;
   typedef enum logic [1:0] {
      EDGE_NONE = 2'b00,
      EDGE_RISE = 2'b01,
      EDGE_FALL = 2'b10,
      EDGE_BOTH = 2'b11
   } edge_sel_e;

   localparam int unsigned REG_CTRL   = 0;
   localparam int unsigned REG_COUNT  = 1;
   localparam int unsigned REG_PINSEL = 2;
   localparam int unsigned REG_CMP0   = 4;

   localparam int unsigned CTRL_RUN  = 0;
   localparam int unsigned CTRL_EXT  = 1;
   localparam int unsigned CTRL_ESEL = 2;
   localparam int unsigned CTRL_W    = 4;

   function automatic logic edge_seen(logic cur, logic prev, edge_sel_e sel);
      logic r;
      unique case (sel)
         EDGE_RISE: r = cur & ~prev;
         EDGE_FALL: r = ~cur & prev;
         EDGE_BOTH: r = cur ^ prev;
         default:   r = 1'b0;
      endcase
      return r;
   endfunction
endpackage

// File: rtl/tmr4_edge_det.sv
module tmr4_edge_det
   import tmr4_pkg::*;
#(
   parameter bit REGISTERED = 1'b1
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      sig_i,
   input  edge_sel_e sel_i,
   output logic      hit_o
);
   logic prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= sig_i;
   end

   generate
      if (REGISTERED) begin : g_reg
         logic hit_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) hit_q <= 1'b0;
            else        hit_q <= edge_seen(sig_i, prev_q, sel_i);
         end
         assign hit_o = hit_q;

         // R9
         none_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (sel_i == EDGE_NONE) |=> !hit_o);
      end else begin : g_comb
         assign hit_o = edge_seen(sig_i, prev_q, sel_i);
      end
   endgenerate
endmodule

// File: rtl/tmr4_counter.sv
module tmr4_counter #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_i,
   input  logic             adv_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic [CNT_W-1:0] nxt_o
);
   logic [CNT_W-1:0] cnt_q;

   assign nxt_o = cnt_q + 1'b1;
   assign cnt_o = cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '1;
      else if (!run_i) cnt_q <= '1;
      else if (adv_i)  cnt_q <= nxt_o;
   end

   // R4
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run_i && !adv_i) |=> $stable(cnt_q));

   // R3
   wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run_i && adv_i && (cnt_q == '1)) |=> (cnt_q == '0));
endmodule

// File: rtl/tmr4_cmp_chan.sv
module tmr4_cmp_chan #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_i,
   input  logic [CNT_W-1:0] wdata_i,
   input  logic             run_i,
   input  logic             adv_i,
   input  logic [CNT_W-1:0] nxt_i,
   output logic [CNT_W-1:0] ccr_o,
   output logic             irq_o
);
   logic [CNT_W-1:0] ccr_q;
   logic [CNT_W-1:0] shadow_q;
   logic             irq_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ccr_q    <= '0;
         shadow_q <= '0;
         irq_q    <= 1'b0;
      end else begin
         if (wr_i) ccr_q <= wdata_i;
         shadow_q <= ccr_q;
         irq_q    <= adv_i && (nxt_i == shadow_q);
      end
   end

   assign ccr_o = ccr_q;
   assign irq_o = irq_q;

   // R8
   stopped_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run_i |=> !irq_o);

   // R6
   shadow_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i ##1 !wr_i) |=> (shadow_q == $past(wdata_i, 2)));

   // R7
   single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o && $stable(shadow_q)) |=> !irq_o);
endmodule

// File: rtl/cmp4_timer.sv
module cmp4_timer
   import tmr4_pkg::*;
#(
   parameter int unsigned CNT_W  = 16,
   parameter int unsigned N_CH   = 4,
   parameter int unsigned N_PIN  = 4,
   parameter int unsigned ADDR_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_en,
   input  logic              evt_in,
   input  logic [N_PIN-1:0]  pin_in,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [CNT_W-1:0]  wdata,
   output logic [CNT_W-1:0]  rdata,
   output logic [N_CH-1:0]   cmp_irq,
   output logic [N_PIN-1:0]  pin_edge
);
   localparam int unsigned PSEL_W = 2 * N_PIN;
   localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(REG_CTRL);
   localparam logic [ADDR_W-1:0] A_COUNT = ADDR_W'(REG_COUNT);
   localparam logic [ADDR_W-1:0] A_PSEL  = ADDR_W'(REG_PINSEL);

   generate
      if (CNT_W < CTRL_W) begin : g_bad_width
         $error("cmp4_timer: CNT_W must hold the control word");
      end
      if (REG_CMP0 + N_CH > (1 << ADDR_W)) begin : g_bad_map
         $error("cmp4_timer: compare channels do not fit the address space");
      end
      if (PSEL_W > CNT_W) begin : g_bad_psel
         $error("cmp4_timer: pin selections do not fit one register");
      end
   endgenerate

   logic [CTRL_W-1:0] ctrl_q;
   logic [PSEL_W-1:0] psel_q;
   logic              run, src_ext, evt_hit, adv;
   logic [CNT_W-1:0]  cnt, nxt;
   logic [CNT_W-1:0]  ccr_arr [N_CH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         psel_q <= '0;
      end else if (wr_en) begin
         if (addr == A_CTRL) ctrl_q <= wdata[CTRL_W-1:0];
         if (addr == A_PSEL) psel_q <= wdata[PSEL_W-1:0];
      end
   end

   assign run     = ctrl_q[CTRL_RUN];
   assign src_ext = ctrl_q[CTRL_EXT];

   tmr4_edge_det #(.REGISTERED(1'b0)) u_evt_det (
      .clk   (clk),
      .rst_n (rst_n),
      .sig_i (evt_in),
      .sel_i (edge_sel_e'(ctrl_q[CTRL_ESEL +: 2])),
      .hit_o (evt_hit)
   );

   assign adv = run && (src_ext ? evt_hit : tick_en);

   tmr4_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .run_i (run),
      .adv_i (adv),
      .cnt_o (cnt),
      .nxt_o (nxt)
   );

   generate
      for (genvar k = 0; k < N_CH; k++) begin : g_ch
         localparam logic [ADDR_W-1:0] A_CMP = ADDR_W'(REG_CMP0 + k);
         tmr4_cmp_chan #(.CNT_W(CNT_W)) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_i    (wr_en && (addr == A_CMP)),
            .wdata_i (wdata),
            .run_i   (run),
            .adv_i   (adv),
            .nxt_i   (nxt),
            .ccr_o   (ccr_arr[k]),
            .irq_o   (cmp_irq[k])
         );
      end

      for (genvar p = 0; p < N_PIN; p++) begin : g_pin
         tmr4_edge_det #(.REGISTERED(1'b1)) u_pin_det (
            .clk   (clk),
            .rst_n (rst_n),
            .sig_i (pin_in[p]),
            .sel_i (edge_sel_e'(psel_q[2*p +: 2])),
            .hit_o (pin_edge[p])
         );
      end
   endgenerate

   always_comb begin
      rdata = '0;
      if (addr == A_CTRL)       rdata = CNT_W'(ctrl_q);
      else if (addr == A_COUNT) rdata = run ? cnt : '0;
      else if (addr == A_PSEL)  rdata = CNT_W'(psel_q);
      for (int k = 0; k < N_CH; k++) begin
         if (addr == ADDR_W'(REG_CMP0 + k)) rdata = ccr_arr[k];
      end
   end

   // R10
   count_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (addr == A_COUNT) && run && !adv) |=> $stable(cnt));
endmodule

// File: tb/cmp4_timer_tb.sv
module cmp4_timer_tb;
   timeunit 1ns;
   timeprecision 100ps;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_en = 1'b0;
   logic        evt_in = 1'b0;
   logic [3:0]  pin_in = '0;
   logic        wr_en = 1'b0;
   logic [2:0]  addr = '0;
   logic [15:0] wdata = '0;
   logic [15:0] rdata;
   logic [3:0]  cmp_irq;
   logic [3:0]  pin_edge;

   int checks = 0;
   int fails = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   cmp4_timer u_dut (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .evt_in(evt_in),
      .pin_in(pin_in), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .rdata(rdata), .cmp_irq(cmp_irq), .pin_edge(pin_edge)
   );

   // {tick_en, expected count, expected irq}; compares 2,5,2,7 loaded
   localparam logic [20:0] VEC [11] = '{
      {1'b1, 16'd0, 4'b0000},
      {1'b0, 16'd0, 4'b0000},
      {1'b1, 16'd1, 4'b0000},
      {1'b1, 16'd2, 4'b0101},
      {1'b0, 16'd2, 4'b0000},
      {1'b1, 16'd3, 4'b0000},
      {1'b1, 16'd4, 4'b0000},
      {1'b1, 16'd5, 4'b0010},
      {1'b1, 16'd6, 4'b0000},
      {1'b1, 16'd7, 4'b1000},
      {1'b0, 16'd7, 4'b0000}
   };

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic rd(input logic [2:0] a, output logic [15:0] v);
      addr = a;
      #0.5;
      v = rdata;
   endtask

   task automatic wr(input logic [2:0] a, input logic [15:0] d);
      wr_en = 1'b1;
      addr  = a;
      wdata = d;
      step();
      wr_en = 1'b0;
   endtask

   task automatic chk_cnt(input string req, input logic [15:0] exp);
      logic [15:0] v;
      rd(3'd1, v);
      chk(req, v, exp);
   endtask

   initial begin
      #(4 * 190000);
      if (!done) begin
         done = 1'b1;
         fails++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [15:0] v;
      step();
      step();
      rst_n = 1'b1;
      step();

      // R1 reset state
      chk_cnt("R1 count", 16'h0000);
      chk("R1 irq", cmp_irq, 4'b0000);
      chk("R1 pin_edge", pin_edge, 4'b0000);
      for (int k = 0; k < 4; k++) begin
         rd(3'(4 + k), v);
         chk("R1 compare", v, 16'h0000);
      end

      // load compare values while stopped
      wr(3'd4, 16'd2);
      wr(3'd5, 16'd5);
      wr(3'd6, 16'd2);
      wr(3'd7, 16'd7);
      step();
      rd(3'd5, v);
      chk("R6 readback", v, 16'd5);
      chk("R8 stopped irq", cmp_irq, 4'b0000);
      chk_cnt("R2 stopped read", 16'h0000);

      // start on internal strobe
      wr(3'd0, 16'h0001);
      chk_cnt("R3 before first step", 16'hFFFF);

      for (int i = 0; i < 11; i++) begin
         tick_en = VEC[i][20];
         step();
         chk_cnt("R4 count", VEC[i][19:4]);
         chk("R7 irq", cmp_irq, VEC[i][3:0]);
      end
      tick_en = 1'b0;

      // R10 write to counter ignored
      wr(3'd1, 16'h1234);
      chk_cnt("R10 count unchanged", 16'd7);

      // compare write versus match in the same cycle
      wr(3'd6, 16'd10);
      step();
      tick_en = 1'b1;
      wr(3'd4, 16'd9);
      chk_cnt("R4 count", 16'd8);
      chk("R6 no early match", cmp_irq, 4'b0000);
      step();
      chk_cnt("R4 count", 16'd9);
      chk("R6 new value not yet in buffer", cmp_irq, 4'b0000);
      wr(3'd6, 16'd30);
      chk_cnt("R4 count", 16'd10);
      chk("R7 old buffer fires on write cycle", cmp_irq, 4'b0100);
      step();
      chk("R7 pulse ends", cmp_irq, 4'b0000);
      rd(3'd6, v);
      chk("R6 readback after write", v, 16'd30);

      // run to the top and wrap: count is 11
      for (int i = 0; i < 65524; i++) step();
      chk_cnt("R3 top", 16'hFFFF);
      step();
      chk_cnt("R3 wrap", 16'h0000);
      chk("R7 no match at zero", cmp_irq, 4'b0000);

      // stop; buffer at FFFF must not fire
      tick_en = 1'b0;
      wr(3'd0, 16'h0000);
      chk_cnt("R2 stopped read", 16'h0000);
      wr(3'd7, 16'hFFFF);
      step();
      tick_en = 1'b1;
      for (int i = 0; i < 3; i++) begin
         step();
         chk("R8 stopped no irq", cmp_irq, 4'b0000);
         chk_cnt("R2 no advance", 16'h0000);
      end

      // external event source, rising edge
      evt_in = 1'b0;
      wr(3'd0, 16'h0007);
      step();
      chk_cnt("R5 strobe ignored", 16'hFFFF);
      evt_in = 1'b1; step();
      chk_cnt("R5 rising", 16'h0000);
      step();
      chk_cnt("R5 level no count", 16'h0000);
      evt_in = 1'b0; step();
      chk_cnt("R5 falling ignored", 16'h0000);
      evt_in = 1'b1; step();
      chk_cnt("R5 rising", 16'h0001);
      wr(3'd0, 16'h000F);
      evt_in = 1'b0; step();
      chk_cnt("R5 both falling", 16'h0002);
      evt_in = 1'b1; step();
      chk_cnt("R5 both rising", 16'h0003);
      wr(3'd0, 16'h0003);
      evt_in = 1'b0; step();
      chk_cnt("R5 none", 16'h0003);
      evt_in = 1'b1; step();
      chk_cnt("R5 none", 16'h0003);
      tick_en = 1'b0;

      // R9 pin edges: pin0 none, pin1 rise, pin2 fall, pin3 both
      wr(3'd2, 16'h00E4);
      pin_in = 4'b1111; step();
      chk("R9 rise", pin_edge, 4'b1010);
      step();
      chk("R9 pulse ends", pin_edge, 4'b0000);
      pin_in = 4'b0000; step();
      chk("R9 fall", pin_edge, 4'b1100);
      step();
      chk("R9 pulse ends", pin_edge, 4'b0000);

      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule